// File: doc/BRIEF.md
# Serial Register Bank Slave

This block is a serial slave that lets an external host read and write a bank of byte-wide registers. A transfer is framed by an active-high chip-enable line. The host shifts bytes in on a data-in line, and the slave shifts bytes out on a separate data-out line. The data-out line has its own output enable, so the two data lines can be tied together into one bidirectional wire. The serial clock, the chip enable and the data-in line come from outside the system clock domain. Each is resynchronised with two flops, and clock edges are found by edge detection.

The first byte of every transfer is a command byte. It carries a direction bit, a fixed sub-address check and a starting register pointer. Every later byte is either written into the register the pointer selects or read from it. After each data byte the pointer steps forward, and it wraps from the top register back to register 0. Inside the chip, a parallel read port shows the contents of any register without involving the serial link.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset, every register reads 0x00 on the host port and the output enable is low.
- R2: Each transfer is a sequence of 8-bit bytes, sent most significant bit first. The first byte after chip enable rises is the command byte, and every later byte is a data byte.
- R3: Command bit 7 chooses the direction. A 0 makes the data bytes writes and a 1 makes them reads.
- R4: Command bits 6..4 must equal 3'b001. Any other value makes the slave ignore the rest of the transfer: no register changes, the output enable stays low and the data output reads 0.
- R5: Command bits 3..0 give the register addressed by the first data byte.
- R6: The register pointer steps by one after every data byte, in both directions, and wraps from 0xF to 0x0.
- R7: A written byte is stored when its eighth bit is sampled, one register per byte. A byte that chip enable cuts off before its eighth bit leaves the registers unchanged.
- R8: In a read, the slave drives each bit on a falling serial clock edge. The first data bit is valid before the first rising edge of the data byte. The output enable is high only in the data phase of a read.
- R9: While chip enable is low, the output enable is low and the byte framing is reset, so the next transfer starts with a fresh command byte.
- R10: The host port returns the current contents of the register selected by `host_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_i | input | 1 | Chip enable, active high |
| mosi_i | input | 1 | Serial data in, sampled on rising sclk |
| miso_o | output | 1 | Serial data out, changes on falling sclk |
| miso_oe_o | output | 1 | Enable for driving the data-out line |
| host_addr_i | input | 4 | Register select for the parallel read port |
| host_data_o | output | 8 | Contents of the selected register |

## Verification
The checks assume that the serial clock is low whenever chip enable changes, and that each serial clock phase spans several system clocks. Data in must also be steady around each rising edge, so that the synchronisers present every edge and its data together. The stimulus keeps to this. It holds each serial clock half period for eight system clocks, changes data in only while the serial clock is low, and waits with the serial clock low before raising or lowering chip enable. It samples data out just before each rising edge, as a host would.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

    // Transfer phase within one chip-enable frame.
    typedef enum logic [1:0] {
        PH_CMD    = 2'd0,
        PH_WRITE  = 2'd1,
        PH_READ   = 2'd2,
        PH_IGNORE = 2'd3
    } xfer_phase_e;

    // Synchronised pin view handed from the front end to the engine.
    typedef struct packed {
        logic cs;
        logic mosi;
        logic rise;
        logic fall;
    } pin_view_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sclk_i,
    input  logic                          cs_i,
    input  logic                          mosi_i,
    output spi_regbank_pkg::pin_view_t    pins_o
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sclk_pipe;
        logic [STAGES-1:0] cs_pipe;
        logic [STAGES-1:0] mosi_pipe;
        logic              sclk_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.sclk_pipe = {s_q.sclk_pipe[STAGES-2:0], sclk_i};
        s_d.cs_pipe   = {s_q.cs_pipe[STAGES-2:0], cs_i};
        s_d.mosi_pipe = {s_q.mosi_pipe[STAGES-2:0], mosi_i};
        s_d.sclk_prev = s_q.sclk_pipe[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        pins_o.cs   = s_q.cs_pipe[LAST];
        pins_o.mosi = s_q.mosi_pipe[LAST];
        pins_o.rise = s_q.sclk_pipe[LAST] & ~s_q.sclk_prev;
        pins_o.fall = ~s_q.sclk_pipe[LAST] & s_q.sclk_prev;
    end

endmodule

// File: rtl/spi_reg_array.sv
module spi_reg_array #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] ser_addr_i,
    output logic [DATA_W-1:0] ser_data_o,
    input  logic [ADDR_W-1:0] host_addr_i,
    output logic [DATA_W-1:0] host_data_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        always_comb begin
            mem_d[gi] = mem_q[gi];
            if (wr_en_i && (wr_addr_i == ADDR_W'(gi))) begin
                mem_d[gi] = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[gi] <= '0;
            end else begin
                mem_q[gi] <= mem_d[gi];
            end
        end
    end

    assign ser_data_o  = mem_q[ser_addr_i];
    assign host_data_o = mem_q[host_addr_i];

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 4,
    parameter logic [2:0]  SUB_CODE = 3'b001
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  spi_regbank_pkg::pin_view_t    pins_i,
    input  logic [DATA_W-1:0]             rd_data_i,
    output logic [ADDR_W-1:0]             ptr_o,
    output logic                          wr_en_o,
    output logic [ADDR_W-1:0]             wr_addr_o,
    output logic [DATA_W-1:0]             wr_data_o,
    output logic                          tx_bit_o,
    output logic                          drive_o,
    output logic [$clog2(DATA_W)-1:0]     bit_cnt_o
);
    import spi_regbank_pkg::*;

    localparam int unsigned CNT_W   = $clog2(DATA_W);
    localparam int unsigned MSB     = DATA_W - 1;
    localparam int unsigned SUB_W   = DATA_W - 1 - ADDR_W;
    localparam int unsigned SUB_LSB = ADDR_W;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        xfer_phase_e       phase;
        logic [CNT_W-1:0]  bit_cnt;
        logic [DATA_W-1:0] rx_sh;
        logic [ADDR_W-1:0] ptr;
        logic [DATA_W-1:0] tx_sh;
        logic              tx_bit;
        logic              drive;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
    } eng_t;

    eng_t e_d, e_q;
    logic [DATA_W-1:0] rx_full;
    logic              byte_last;
    logic              sub_ok;

    always_comb begin
        e_d       = e_q;
        e_d.wr_en = 1'b0;
        rx_full   = {e_q.rx_sh[DATA_W-2:0], pins_i.mosi};
        byte_last = (e_q.bit_cnt == LAST_BIT);
        sub_ok    = (rx_full[SUB_LSB +: SUB_W] == SUB_W'(SUB_CODE));

        if (!pins_i.cs) begin
            e_d.phase   = PH_CMD;
            e_d.bit_cnt = '0;
            e_d.drive   = 1'b0;
            e_d.tx_bit  = 1'b0;
        end else begin
            if (pins_i.rise) begin
                e_d.rx_sh   = rx_full;
                e_d.bit_cnt = byte_last ? '0 : e_q.bit_cnt + 1'b1;
                if (byte_last) begin
                    unique case (e_q.phase)
                        PH_CMD: begin
                            if (sub_ok) begin
                                e_d.phase = rx_full[MSB] ? PH_READ : PH_WRITE;
                                e_d.ptr   = rx_full[ADDR_W-1:0];
                            end else begin
                                e_d.phase = PH_IGNORE;
                            end
                        end
                        PH_WRITE: begin
                            e_d.wr_en   = 1'b1;
                            e_d.wr_addr = e_q.ptr;
                            e_d.wr_data = rx_full;
                            e_d.ptr     = e_q.ptr + 1'b1;
                        end
                        PH_READ: begin
                            e_d.ptr = e_q.ptr + 1'b1;
                        end
                        default: begin
                            e_d.phase = PH_IGNORE;
                        end
                    endcase
                end
            end

            if (pins_i.fall && (e_q.phase == PH_READ)) begin
                e_d.drive = 1'b1;
                if (e_q.bit_cnt == '0) begin
                    e_d.tx_bit = rd_data_i[MSB];
                    e_d.tx_sh  = {rd_data_i[DATA_W-2:0], 1'b0};
                end else begin
                    e_d.tx_bit = e_q.tx_sh[MSB];
                    e_d.tx_sh  = {e_q.tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{phase: PH_CMD, default: '0};
        end else begin
            e_q <= e_d;
        end
    end

    assign ptr_o     = e_q.ptr;
    assign wr_en_o   = e_q.wr_en;
    assign wr_addr_o = e_q.wr_addr;
    assign wr_data_o = e_q.wr_data;
    assign tx_bit_o  = e_q.tx_bit;
    assign drive_o   = e_q.drive;
    assign bit_cnt_o = e_q.bit_cnt;

endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 4,
    parameter logic [2:0]  SUB_CODE = 3'b001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic [ADDR_W-1:0] host_addr_i,
    output logic [DATA_W-1:0] host_data_o
);
    localparam int unsigned CNT_W = $clog2(DATA_W);

    spi_regbank_pkg::pin_view_t pins;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] ptr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              tx_bit;
    logic              drive;
    logic [CNT_W-1:0]  bit_cnt;

    spi_pin_sync #(.STAGES(2)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk_i),
        .cs_i   (cs_i),
        .mosi_i (mosi_i),
        .pins_o (pins)
    );

    spi_cmd_engine #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .SUB_CODE (SUB_CODE)
    ) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_i    (pins),
        .rd_data_i (rd_data),
        .ptr_o     (ptr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .tx_bit_o  (tx_bit),
        .drive_o   (drive),
        .bit_cnt_o (bit_cnt)
    );

    spi_reg_array #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .ser_addr_i  (ptr),
        .ser_data_o  (rd_data),
        .host_addr_i (host_addr_i),
        .host_data_o (host_data_o)
    );

    // Gate with the raw chip enable so the line is released at once.
    assign miso_oe_o = drive & cs_i;
    assign miso_o    = tx_bit & miso_oe_o;

endmodule

// File: rtl/spi_regbank_checker.sv
module spi_regbank_checker #(
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_i,
    input logic             miso_o,
    input logic             miso_oe_o,
    input logic             cs_s,
    input logic             sclk_fall,
    input logic             wr_en,
    input logic [CNT_W-1:0] bit_cnt
);
    // R9: data-out line is released whenever chip enable is low.
    assert_oe_off_without_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |-> !miso_oe_o);

    // R9: framing counter is cleared one cycle after synchronised chip enable drops.
    assert_cs_clears_framing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> (bit_cnt == '0));

    // R8: while driven, data out only moves after a falling serial clock edge.
    assert_miso_moves_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe_o && !sclk_fall) |=> (!miso_oe_o || $stable(miso_o)));

    // R7: one write strobe per byte, never on consecutive cycles.
    assert_single_write_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R7: a write only follows a cycle with chip enable present.
    assert_write_inside_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(cs_s));
endmodule

bind spi_regbank_slave spi_regbank_checker #(.CNT_W(CNT_W)) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_i      (cs_i),
    .miso_o    (miso_o),
    .miso_oe_o (miso_oe_o),
    .cs_s      (pins.cs),
    .sclk_fall (pins.fall),
    .wr_en     (wr_en),
    .bit_cnt   (bit_cnt)
);

// File: tb/test_spi_regbank_slave.sv
module test_spi_regbank_slave;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic       miso_oe;
    logic [3:0] host_addr = '0;
    logic [7:0] host_data;

    int total = 0;
    int bad = 0;
    logic [7:0] model [16];
    logic [7:0] txb [32];
    logic [7:0] rxb [32];
    logic oe_seen = 1'b0;
    logic oe_missing = 1'b0;

    always #4 clk = ~clk;

    spi_regbank_slave i_spi_regbank_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk),
        .cs_i        (cs),
        .mosi_i      (mosi),
        .miso_o      (miso),
        .miso_oe_o   (miso_oe),
        .host_addr_i (host_addr),
        .host_data_o (host_data)
    );

    always @(negedge clk) if (cs && miso_oe) oe_seen <= 1'b1;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One byte, MSB first; samples data out just before each rising edge.
    task automatic shift_byte(input logic [7:0] b, input int nbits, input logic rd, output logic [7:0] got);
        got = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = b[i];
            wait_clk(HALF);
            got[i] = miso;
            if (rd && !miso_oe) oe_missing = 1'b1;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    // Command plus n data bytes; last byte may be cut to tail bits.
    task automatic xfer(input logic [7:0] cmd, input int n, input int tail, input logic rd);
        logic [7:0] g;
        oe_seen = 1'b0;
        oe_missing = 1'b0;
        cs = 1'b1;
        wait_clk(HALF);
        shift_byte(cmd, 8, 1'b0, g);
        for (int k = 0; k < n; k++) begin
            shift_byte(txb[k], (k == n - 1) ? tail : 8, rd, g);
            rxb[k] = g;
        end
        wait_clk(HALF);
        cs = 1'b0;
        wait_clk(6);
    endtask

    task automatic check_bank(input string req);
        for (int a = 0; a < 16; a++) begin
            host_addr = 4'(a);
            wait_clk(1);
            chk(req, host_data, model[a]);
        end
    endtask

    initial begin
        for (int a = 0; a < 16; a++) model[a] = '0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R1 oe after reset", {7'd0, miso_oe}, 8'd0);
        check_bank("R1/R10 reset contents");

        // Writes from every start address, three bytes each, crossing the wrap.
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 3; k++) begin
                txb[k] = 8'((s * 29 + k * 13 + 7) ^ (k << 6));
                model[(s + k) % 16] = txb[k];
            end
            xfer({1'b0, 3'b001, 4'(s)}, 3, 8, 1'b0);
            chk("R8 no drive in write", {7'd0, oe_seen}, 8'd0);
            check_bank("R3/R5/R6/R7 write burst");
        end

        // Reads from every start address through a full wrap.
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 17; k++) txb[k] = 8'hFF;
            xfer({1'b1, 3'b001, 4'(s)}, 17, 8, 1'b1);
            for (int k = 0; k < 17; k++)
                chk("R2/R3/R6/R8 read burst", rxb[k], model[(s + k) % 16]);
            chk("R8 drive during read", {7'd0, oe_missing}, 8'd0);
            chk("R9 oe low after frame", {7'd0, miso_oe}, 8'd0);
        end

        // Wrong sub-address codes, both directions.
        for (int sub = 0; sub < 8; sub++) begin
            if (sub == 1) continue;
            txb[0] = 8'hA5;
            txb[1] = 8'h5A;
            xfer({1'b0, 3'(sub), 4'(sub)}, 2, 8, 1'b0);
            chk("R4 ignored write no drive", {7'd0, oe_seen}, 8'd0);
            check_bank("R4 ignored write");
            xfer({1'b1, 3'(sub), 4'(sub)}, 2, 8, 1'b0);
            chk("R4 ignored read no drive", {7'd0, oe_seen}, 8'd0);
            chk("R4 ignored read data", rxb[0] | rxb[1], 8'd0);
        end

        // Partial byte cut by chip enable.
        txb[0] = 8'h3C;
        txb[1] = 8'hC3;
        model[3] = 8'h3C;
        xfer({1'b0, 3'b001, 4'd3}, 2, 5, 1'b0);
        check_bank("R7 partial byte dropped");

        // Fresh framing after the cut frame.
        txb[0] = 8'h00;
        xfer({1'b1, 3'b001, 4'd3}, 1, 8, 1'b1);
        chk("R9 reframe after cut", rxb[0], 8'h3C);
        chk("R9 oe low idle", {7'd0, miso_oe}, 8'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule